// File: doc/BRIEF.md
# Serial Port Interrupt Enable and Identification Logic

This block holds the interrupt enable register of a 16550-style serial controller and produces its interrupt identification value and single interrupt line. A host bus writes the enable register and can read it back at any time. Four raw condition inputs arrive from the rest of the controller: receiver line status, received data available (with a separate character-timeout input), transmit holding register empty, and modem status. A mode input says whether the receive and transmit FIFOs are enabled.

Each condition is masked by its enable bit. The highest-priority enabled condition is encoded in the low nibble of the identification value, and the interrupt line is raised whenever any enabled condition is pending. The identification value and the interrupt line are combinational, so they follow the condition inputs in the same cycle. An enable write takes effect on the clock edge that captures it. In FIFO mode the identification value carries a distinct timeout code and two mode indicator bits.

Top module: `uart_irq_ctrl`

## Requirements
- R1: When `ier_we` is high at a rising clock edge, bits 3:0 of `ier_wdata` are stored in the enable register. From the next cycle `ier_rdata[3:0]` returns them. Bit 0 enables received-data (and timeout), bit 1 transmit-empty, bit 2 line-status and bit 3 modem-status.
- R2: `ier_rdata[7:4]` always reads 0, whatever value was written.
- R3: When enable bits 3:0 are all zero, `irq` stays low and `iir_rdata[3:0]` reads 0001, whatever the condition inputs do.
- R4: `iir_rdata[0]` is 0 exactly when an enabled condition is pending, and 1 otherwise. `irq` is high exactly when `iir_rdata[0]` is 0.
- R5: Fixed priority with these `iir_rdata[3:0]` codes: line status 0110 (highest), then received data 0100, then transmit empty 0010, then modem status 0000 (lowest).
- R6: In FIFO mode, with bit 0 enabled, an active `rx_timeout` and an inactive `rx_data_rdy` give code 1100. It has the same priority level as received data, and `rx_data_rdy` takes precedence over it. Line status still outranks it.
- R7: With FIFO mode off, `rx_timeout` is ignored and `iir_rdata[3]` is always 0.
- R8: `iir_rdata[5:4]` always reads 0. `iir_rdata[7:6]` reads 11 when `fifo_en` is high and 00 when it is low.
- R9: A synchronous active-high `rst` clears the enable register. After reset, `ier_rdata` reads 0x00 and `iir_rdata` reads 0x01 with FIFO mode off, or 0xC1 with it on.
- R10: A condition whose enable bit is 0 has no effect on `irq` or `iir_rdata`. A lower-priority enabled condition is then reported in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| fifo_en | input | 1 | FIFO mode selector |
| rx_line_stat | input | 1 | Receiver line status condition |
| rx_data_rdy | input | 1 | Received data available condition |
| rx_timeout | input | 1 | Receive character timeout condition |
| tx_hold_empty | input | 1 | Transmit holding register empty condition |
| modem_stat | input | 1 | Modem status condition |
| ier_rdata | output | 8 | Enable register read value |
| iir_rdata | output | 8 | Identification register read value |
| irq | output | 1 | Interrupt output, active high |

## Verification
The only state in the block is the four-bit enable register. A corrupted or stale enable bit shows up at the ports in the first cycle after the write: either directly on `ier_rdata`, or as a wrong code on `iir_rdata` and a wrong `irq` level. This happens once a condition gated by that bit is presented alongside conditions of neighbouring priority. A faulty priority or mask path has no memory, so it appears in the same cycle as the offending condition pattern. For this reason the stimulus combines several active conditions under different enable masks and in both modes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int unsigned SRC_CNT   = 4;
   localparam int unsigned CODE_W    = 4;

   // bit positions inside the enable register
   localparam int unsigned EN_RDA  = 0;
   localparam int unsigned EN_THRE = 1;
   localparam int unsigned EN_LSR  = 2;
   localparam int unsigned EN_MSR  = 3;

   // low nibble codes of the identification value
   localparam logic [CODE_W-1:0] CODE_LSR  = 4'b0110;
   localparam logic [CODE_W-1:0] CODE_RDA  = 4'b0100;
   localparam logic [CODE_W-1:0] CODE_CTO  = 4'b1100;
   localparam logic [CODE_W-1:0] CODE_THRE = 4'b0010;
   localparam logic [CODE_W-1:0] CODE_MSR  = 4'b0000;
   localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

   typedef struct packed {
      logic lsr;
      logic rda;
      logic cto;
      logic thre;
      logic msr;
   } irq_src_t;

endpackage

// File: rtl/uart_irq_ier.sv
module uart_irq_ier #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned EN_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [EN_W-1:0]   en,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned PAD_W = DATA_W - EN_W;

   generate
      if (EN_W == 0 || EN_W >= DATA_W) begin : g_bad_w
         $error("uart_irq_ier: EN_W must be between 1 and DATA_W-1");
      end
   endgenerate

   logic [EN_W-1:0] en_q;

   always_ff @(posedge clk) begin
      if (rst) en_q <= '0;
      else if (we) en_q <= wdata[EN_W-1:0];
   end

   assign en    = en_q;
   assign rdata = {{PAD_W{1'b0}}, en_q};

   p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
      we |=> (rdata[EN_W-1:0] == $past(wdata[EN_W-1:0])));
   p_hold_no_write_r1: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(rdata));
   p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
      rdata[DATA_W-1:EN_W] == '0);
   p_reset_clears_r9: assert property (@(posedge clk)
      rst |=> (rdata == '0));
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
   import uart_irq_pkg::*;
#(
   parameter int unsigned EN_W = 4
) (
   input  logic            fifo_en,
   input  logic [EN_W-1:0] en,
   input  irq_src_t        raw,
   output irq_src_t        gated
);
   generate
      if (EN_W != SRC_CNT) begin : g_bad_w
         $error("uart_irq_mask: EN_W must equal SRC_CNT");
      end
   endgenerate

   // per-source gating, one enable bit per source position
   localparam int unsigned IDX [SRC_CNT] = '{EN_RDA, EN_THRE, EN_LSR, EN_MSR};

   logic [SRC_CNT-1:0] raw_v;
   logic [SRC_CNT-1:0] gate_v;

   assign raw_v[0] = raw.rda;
   assign raw_v[1] = raw.thre;
   assign raw_v[2] = raw.lsr;
   assign raw_v[3] = raw.msr;

   genvar gi;
   generate
      for (gi = 0; gi < SRC_CNT; gi++) begin : g_gate
         assign gate_v[gi] = raw_v[gi] & en[IDX[gi]];
      end
   endgenerate

   always_comb begin
      gated.rda  = gate_v[0];
      gated.thre = gate_v[1];
      gated.lsr  = gate_v[2];
      gated.msr  = gate_v[3];
      // timeout exists only with FIFOs; shares the received-data enable
      gated.cto  = raw.cto & fifo_en & en[EN_RDA];
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  irq_src_t          gated,
   output logic [CODE_W-1:0] code,
   output logic              pending
);
   always_comb begin
      if      (gated.lsr)  code = CODE_LSR;
      else if (gated.rda)  code = CODE_RDA;
      else if (gated.cto)  code = CODE_CTO;
      else if (gated.thre) code = CODE_THRE;
      else if (gated.msr)  code = CODE_MSR;
      else                 code = CODE_NONE;
   end

   assign pending = ~code[0];

   p_lsr_top_r5: assert property (@(posedge clk) disable iff (rst)
      gated.lsr |-> (code == CODE_LSR));
   p_rda_over_cto_r6: assert property (@(posedge clk) disable iff (rst)
      (!gated.lsr && gated.rda) |-> (code == CODE_RDA));
   p_none_flag_r4: assert property (@(posedge clk) disable iff (rst)
      (gated == '0) |-> (code == CODE_NONE));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned EN_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ier_we,
   input  logic [DATA_W-1:0] ier_wdata,
   input  logic              fifo_en,
   input  logic              rx_line_stat,
   input  logic              rx_data_rdy,
   input  logic              rx_timeout,
   input  logic              tx_hold_empty,
   input  logic              modem_stat,
   output logic [DATA_W-1:0] ier_rdata,
   output logic [DATA_W-1:0] iir_rdata,
   output logic              irq
);
   localparam int unsigned MID_W = DATA_W - CODE_W - 2;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("uart_irq_ctrl: register width must be 8");
      end
   endgenerate

   logic [EN_W-1:0]   en;
   irq_src_t          raw;
   irq_src_t          gated;
   logic [CODE_W-1:0] code;
   logic              pending;

   assign raw = '{lsr: rx_line_stat, rda: rx_data_rdy, cto: rx_timeout,
                  thre: tx_hold_empty, msr: modem_stat};

   uart_irq_ier #(.DATA_W(DATA_W), .EN_W(EN_W)) u_ier (
      .clk(clk), .rst(rst), .we(ier_we), .wdata(ier_wdata),
      .en(en), .rdata(ier_rdata));

   uart_irq_mask #(.EN_W(EN_W)) u_mask (
      .fifo_en(fifo_en), .en(en), .raw(raw), .gated(gated));

   uart_irq_prio u_prio (
      .clk(clk), .rst(rst), .gated(gated), .code(code), .pending(pending));

   assign iir_rdata = {{2{fifo_en}}, {MID_W{1'b0}}, code};
   assign irq       = pending;

   p_all_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (ier_rdata[EN_W-1:0] == '0) |-> (!irq && iir_rdata[3:0] == CODE_NONE));
   p_irq_flag_r4: assert property (@(posedge clk) disable iff (rst)
      irq != iir_rdata[0]);
   p_no_cto_bit_r7: assert property (@(posedge clk) disable iff (rst)
      !fifo_en |-> !iir_rdata[3]);
   p_mode_bits_r8: assert property (@(posedge clk) disable iff (rst)
      (iir_rdata[7:6] == {2{fifo_en}}) && (iir_rdata[5:4] == 2'b00));
   p_masked_lsr_r10: assert property (@(posedge clk) disable iff (rst)
      !ier_rdata[EN_LSR] |-> (iir_rdata[3:0] != CODE_LSR));
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst;
   logic       ier_we;
   logic [7:0] ier_wdata;
   logic       fifo_en;
   logic       lsr, rda, cto, thre, msr;
   logic [7:0] ier_rdata, iir_rdata;
   logic       irq;

   int n_vec  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   uart_irq_ctrl u0 (
      .clk(clk), .rst(rst), .ier_we(ier_we), .ier_wdata(ier_wdata),
      .fifo_en(fifo_en), .rx_line_stat(lsr), .rx_data_rdy(rda),
      .rx_timeout(cto), .tx_hold_empty(thre), .modem_stat(msr),
      .ier_rdata(ier_rdata), .iir_rdata(iir_rdata), .irq(irq));

   // {fifo, ier[3:0], lsr rda cto thre msr, iir, irq}
   localparam int NV = 17;
   localparam logic [18:0] VEC [NV] = '{
      {1'b0, 4'hF, 5'b11111, 8'h06, 1'b1},   // R5 lsr wins
      {1'b0, 4'hF, 5'b01111, 8'h04, 1'b1},   // R5 rda next
      {1'b0, 4'hF, 5'b00111, 8'h02, 1'b1},   // R7 cto ignored, thre
      {1'b0, 4'hF, 5'b00011, 8'h02, 1'b1},   // R5 thre over msr
      {1'b0, 4'hF, 5'b00001, 8'h00, 1'b1},   // R5 msr alone
      {1'b0, 4'hF, 5'b00100, 8'h01, 1'b0},   // R7 cto alone, no fifo
      {1'b1, 4'hF, 5'b00100, 8'hCC, 1'b1},   // R6 timeout code
      {1'b1, 4'hF, 5'b01100, 8'hC4, 1'b1},   // R6 rda beats cto
      {1'b1, 4'hF, 5'b10100, 8'hC6, 1'b1},   // R6 lsr beats cto
      {1'b0, 4'hB, 5'b11111, 8'h04, 1'b1},   // R10 lsr masked
      {1'b0, 4'hA, 5'b11111, 8'h02, 1'b1},   // R10 lsr rda masked
      {1'b0, 4'h8, 5'b11111, 8'h00, 1'b1},   // R10 only msr enabled
      {1'b0, 4'h0, 5'b11111, 8'h01, 1'b0},   // R3 all off
      {1'b1, 4'h0, 5'b11111, 8'hC1, 1'b0},   // R3 R8 all off, fifo
      {1'b0, 4'h4, 5'b01011, 8'h01, 1'b0},   // R10 only lsr enabled, absent
      {1'b1, 4'hE, 5'b01100, 8'hC1, 1'b0},   // R10 bit0 masks rda and cto
      {1'b0, 4'h1, 5'b01000, 8'h04, 1'b1}    // R1 bit0 alone
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_ier(input logic [7:0] d);
      @(negedge clk);
      ier_we = 1'b1; ier_wdata = d;
      @(negedge clk);
      ier_we = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected < 100000", cycles);
         summary();
      end
   end

   initial begin
      rst = 1'b1; ier_we = 1'b0; ier_wdata = 8'h00; fifo_en = 1'b0;
      {lsr, rda, cto, thre, msr} = 5'b00000;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check8("R9 ier after reset", ier_rdata, 8'h00);
      check8("R9 iir after reset", iir_rdata, 8'h01);
      fifo_en = 1'b1; #1;
      check8("R9 R8 iir after reset fifo", iir_rdata, 8'hC1);
      fifo_en = 1'b0;

      for (int i = 0; i < NV; i++) begin
         logic [18:0] v;
         v = VEC[i];
         write_ier({4'h5, v[17:14]});          // junk in upper bits
         fifo_en = v[18];
         {lsr, rda, cto, thre, msr} = v[13:9];
         #1;
         check8("R1 R2 ier readback", ier_rdata, {4'h0, v[17:14]});
         check8("R5 R6 R7 R10 iir", iir_rdata, v[8:1]);
         check8("R4 irq", {7'd0, irq}, {7'd0, v[0]});
      end

      // R1: write not visible before capturing edge
      fifo_en = 1'b0; {lsr, rda, cto, thre, msr} = 5'b00010;
      write_ier(8'h00);
      @(negedge clk);
      ier_we = 1'b1; ier_wdata = 8'h02; #1;
      check8("R1 before edge", {7'd0, irq}, 8'h00);
      @(negedge clk); ier_we = 1'b0; #1;
      check8("R1 after edge", iir_rdata, 8'h02);
      check8("R4 irq after write", {7'd0, irq}, 8'h01);

      // R2: all ones written
      write_ier(8'hFF); #1;
      check8("R2 upper bits", ier_rdata, 8'h0F);

      // R9: reset mid-run clears enables
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0; #1;
      check8("R9 ier cleared", ier_rdata, 8'h00);
      check8("R9 R3 iir idle", iir_rdata, 8'h01);

      summary();
   end
endmodule